// File: doc/BRIEF.md
# Flash Command Sequence Interpreter

This block is the command front end of a byte-wide parallel NOR flash. It receives host write cycles and read requests. It checks multi-cycle command sequences that are gated by two unlock writes, and it decides what each read returns: array bytes, identification codes, or a progress status byte while an embedded program operation runs. A program request leaves the block as a one-cycle start pulse carrying the latched target address and data byte. A separate timer, outside this block, answers with a completion pulse when the operation is done.

Both host-facing streams are valid-only. A write cycle is taken in every clock where `wr_valid` is high. A read request is taken in every clock where `rd_req` is high, and its response appears on `rd_valid`/`rd_data` exactly one clock later. The block never applies back-pressure, so no ready signals exist. The storage array is external. It is read combinationally through `arr_raddr`/`arr_rdata`. Per-sector protection bits are loaded through a small write port.

Command encodings are as follows. The first unlock is AAh written at command address 555h. The second unlock is 55h written at 2AAh. The program set-up is A0h at 555h. Autoselect is 90h at 555h. Reset is F0h at any address. A command address is the low 11 bits of the write address. The sector index is the top `SECT_W` bits of an address.

Top module: `flash_cmd_seq`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it rises, `mode` is read-array (0), and `prog_start` and `rd_valid` are low.
- R2: A read request is answered one clock later with `rd_valid` high. In read-array mode (0) and in command-pending mode (2), the returned byte is `arr_rdata` for the requested address.
- R3: The writes AAh@555h, 55h@2AAh, A0h@555h, then any non-F0h byte D at address A in an unprotected sector, raise `prog_start` for exactly one clock with `prog_addr`=A and `prog_data`=D. `mode` becomes busy (3) in that same clock. `mode` is pending (2) after the first unlock, after the second unlock and after the set-up write.
- R4: A wrong address or data value in either unlock cycle, or in the command cycle, returns `mode` to read-array. No later write then starts a program without a fresh full sequence.
- R5: F0h written at any address after the first unlock and before the operation starts returns `mode` to read-array without a start pulse. This includes F0h written as the fourth cycle of a program sequence.
- R6: While busy, every write is ignored, including F0h and complete unlock sequences. `mode` stays busy until `prog_done`, and is read-array in the clock after `prog_done`.
- R7: A read while busy returns a status byte. Bit 7 is the inverse of bit 7 of the byte being programmed. Bit 6 is 0 on the first busy read and inverts on each further busy read. Bits 5..0 are 0.
- R8: AAh@555h, 55h@2AAh, 90h@555h enters autoselect mode (1). Any number of reads and non-F0h writes leave it there, and F0h at any address exits to read-array.
- R9: In autoselect mode, the low address byte picks the returned value. 00h returns `MFR_CODE` (default 01h). 01h returns `DEV_CODE` (default 38h). 02h returns 01h if the sector in the address top bits is protected, else 00h. Any other offset returns 00h.
- R10: A high `prot_we` sets the protection bit of sector `prot_sector` to `prot_value` from the next clock. A program sequence aimed at a protected sector ends in read-array with no start pulse and no busy period.
- R11: `prog_done` outside busy has no effect. A write in the same clock as `prog_done` during busy is dropped. A read in the same clock as any write or `prog_done` is answered from the mode held before that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write cycle present this clock |
| wr_addr | input | ADDR_W | Write cycle address |
| wr_data | input | 8 | Write cycle data |
| rd_req | input | 1 | Read request this clock |
| rd_addr | input | ADDR_W | Read address |
| rd_valid | output | 1 | Read response valid, one clock after the request |
| rd_data | output | 8 | Read response byte |
| arr_raddr | output | ADDR_W | Address presented to the external array |
| arr_rdata | input | 8 | Array byte at `arr_raddr`, same clock |
| prog_start | output | 1 | One-clock start request to the program timer |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | 8 | Latched program data |
| prog_done | input | 1 | Completion pulse from the program timer |
| prot_we | input | 1 | Load one protection bit |
| prot_sector | input | SECT_W | Sector to load |
| prot_value | input | 1 | New protection value |
| mode | output | 2 | 0 read-array, 1 autoselect, 2 command pending, 3 busy |

## Verification
Two events can meet in one clock. The first is a host write arriving in the clock where the timer raises `prog_done`. That write must be dropped, since the block is still busy when the clock edge arrives. The bench times an AAh@555h write onto the completion clock and follows it with 55h@2AAh. The following `mode` values show whether that first unlock was wrongly accepted. Reads that share a clock with writes, and with the completion pulse, are judged the same way: the reference model answers them from the mode held before that edge.

// File: rtl/fcsi_pkg.sv
package fcsi_pkg;
  typedef enum logic [1:0] {
    MODE_READ = 2'd0,
    MODE_AUTO = 2'd1,
    MODE_PEND = 2'd2,
    MODE_BUSY = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    ST_READ, ST_UNL1, ST_UNL2, ST_SETUP, ST_AUTO, ST_BUSY
  } seq_st_e;

  localparam int CMD_AW = 11;
  localparam logic [CMD_AW-1:0] ADR_UNL_A = 11'h555;
  localparam logic [CMD_AW-1:0] ADR_UNL_B = 11'h2AA;

  localparam logic [7:0] CMD_UNL_A = 8'hAA;
  localparam logic [7:0] CMD_UNL_B = 8'h55;
  localparam logic [7:0] CMD_PROG  = 8'hA0;
  localparam logic [7:0] CMD_AUTO  = 8'h90;
  localparam logic [7:0] CMD_RESET = 8'hF0;

  localparam logic [7:0] OFS_MFR  = 8'h00;
  localparam logic [7:0] OFS_DEV  = 8'h01;
  localparam logic [7:0] OFS_PROT = 8'h02;
endpackage

// File: rtl/fcsi_prot.sv
module fcsi_prot #(
  parameter int SECT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SECT_W-1:0] wsel,
  input  logic              wval,
  input  logic [SECT_W-1:0] chk_sel,
  output logic              chk_prot,
  input  logic [SECT_W-1:0] rd_sel,
  output logic              rd_prot
);
  localparam int NSECT = 1 << SECT_W;

  logic [NSECT-1:0] bits;

  for (genvar s = 0; s < NSECT; s++) begin : g_sect
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits[s] <= 1'b0;
      end else if (we && wsel == SECT_W'(s)) begin
        bits[s] <= wval;
      end
    end
  end

  assign chk_prot = bits[chk_sel];
  assign rd_prot  = bits[rd_sel];
endmodule

// File: rtl/fcsi_seq.sv
module fcsi_seq
  import fcsi_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              prog_done,
  input  logic              prot_hit,
  output mode_e             mode,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data
);
  seq_st_e st, st_nxt;
  logic    start_nxt;
  logic    is_reset;
  logic    at_a, at_b;

  assign is_reset = (wr_data == CMD_RESET);
  assign at_a     = (wr_addr[CMD_AW-1:0] == ADR_UNL_A);
  assign at_b     = (wr_addr[CMD_AW-1:0] == ADR_UNL_B);

  always_comb begin
    st_nxt    = st;
    start_nxt = 1'b0;
    unique case (st)
      ST_READ: begin
        if (wr_valid && at_a && wr_data == CMD_UNL_A) st_nxt = ST_UNL1;
      end
      ST_UNL1: begin
        if (wr_valid) st_nxt = (at_b && wr_data == CMD_UNL_B) ? ST_UNL2 : ST_READ;
      end
      ST_UNL2: begin
        if (wr_valid) begin
          if (at_a && wr_data == CMD_PROG)      st_nxt = ST_SETUP;
          else if (at_a && wr_data == CMD_AUTO) st_nxt = ST_AUTO;
          else                                  st_nxt = ST_READ;
        end
      end
      ST_SETUP: begin
        if (wr_valid) begin
          if (is_reset || prot_hit) begin
            st_nxt = ST_READ;
          end else begin
            st_nxt    = ST_BUSY;
            start_nxt = 1'b1;
          end
        end
      end
      ST_AUTO: begin
        if (wr_valid && is_reset) st_nxt = ST_READ;
      end
      ST_BUSY: begin
        if (prog_done) st_nxt = ST_READ;
      end
      default: st_nxt = ST_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_READ;
      prog_start <= 1'b0;
      prog_addr  <= '0;
      prog_data  <= '0;
    end else begin
      st         <= st_nxt;
      prog_start <= start_nxt;
      if (start_nxt) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
    end
  end

  always_comb begin
    unique case (st)
      ST_READ:                    mode = MODE_READ;
      ST_AUTO:                    mode = MODE_AUTO;
      ST_BUSY:                    mode = MODE_BUSY;
      ST_UNL1, ST_UNL2, ST_SETUP: mode = MODE_PEND;
      default:                    mode = MODE_READ;
    endcase
  end
endmodule

// File: rtl/fcsi_rdmux.sv
module fcsi_rdmux
  import fcsi_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  mode_e             mode,
  input  logic [7:0]        arr_rdata,
  input  logic              sect_prot,
  input  logic              pdata_msb,
  output logic              rd_valid,
  output logic [7:0]        rd_data
);
  logic       tog;
  logic [7:0] id_byte;
  logic [7:0] sel_byte;

  always_comb begin
    unique case (rd_addr[7:0])
      OFS_MFR:  id_byte = MFR_CODE;
      OFS_DEV:  id_byte = DEV_CODE;
      OFS_PROT: id_byte = {7'b0, sect_prot};
      default:  id_byte = 8'h00;
    endcase
  end

  always_comb begin
    unique case (mode)
      MODE_BUSY: sel_byte = {~pdata_msb, tog, 6'b0};
      MODE_AUTO: sel_byte = id_byte;
      default:   sel_byte = arr_rdata;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog      <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= sel_byte;
      if (mode != MODE_BUSY) tog <= 1'b0;
      else if (rd_req)       tog <= ~tog;
    end
  end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcsi_pkg::*;
#(
  parameter int         ADDR_W   = 12,
  parameter int         SECT_W   = 3,
  parameter logic [7:0] MFR_CODE = 8'h01,
  parameter logic [7:0] DEV_CODE = 8'h38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [7:0]        arr_rdata,
  output logic              prog_start,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  input  logic              prog_done,
  input  logic              prot_we,
  input  logic [SECT_W-1:0] prot_sector,
  input  logic              prot_value,
  output logic [1:0]        mode
);
  localparam int SECT_LSB = ADDR_W - SECT_W;

  mode_e mode_i;
  logic  wr_prot, rd_prot;

  assign arr_raddr = rd_addr;
  assign mode      = mode_i;

  fcsi_prot #(.SECT_W(SECT_W)) u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (prot_we),
    .wsel     (prot_sector),
    .wval     (prot_value),
    .chk_sel  (wr_addr[ADDR_W-1:SECT_LSB]),
    .chk_prot (wr_prot),
    .rd_sel   (rd_addr[ADDR_W-1:SECT_LSB]),
    .rd_prot  (rd_prot)
  );

  fcsi_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid   (wr_valid),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .prog_done  (prog_done),
    .prot_hit   (wr_prot),
    .mode       (mode_i),
    .prog_start (prog_start),
    .prog_addr  (prog_addr),
    .prog_data  (prog_data)
  );

  fcsi_rdmux #(
    .ADDR_W   (ADDR_W),
    .MFR_CODE (MFR_CODE),
    .DEV_CODE (DEV_CODE)
  ) u_rdmux (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .mode      (mode_i),
    .arr_rdata (arr_rdata),
    .sect_prot (rd_prot),
    .pdata_msb (prog_data[7]),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [7:0]        wr_data,
  input logic              rd_req,
  input logic              rd_valid,
  input logic              prog_start,
  input logic [ADDR_W-1:0] prog_addr,
  input logic              prog_done,
  input logic [1:0]        mode
);
  localparam logic [1:0] M_READ = 2'd0;
  localparam logic [1:0] M_AUTO = 2'd1;
  localparam logic [1:0] M_BUSY = 2'd3;

  p_rd_resp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |-> mode == M_BUSY);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BUSY && !prog_done) |=> mode == M_BUSY);
  p_busy_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BUSY && prog_done) |=> mode == M_READ);
  p_busy_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BUSY && !prog_start) |-> $stable(prog_addr));
  p_auto_stay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_AUTO && !(wr_valid && wr_data == 8'hF0)) |=> mode == M_AUTO);
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_data    (wr_data),
  .rd_req     (rd_req),
  .rd_valid   (rd_valid),
  .prog_start (prog_start),
  .prog_addr  (prog_addr),
  .prog_done  (prog_done),
  .mode       (mode)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int AW = 12;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic          rd_valid;
  logic [7:0]    rd_data;
  logic [AW-1:0] arr_raddr;
  logic [7:0]    arr_rdata;
  logic          prog_start;
  logic [AW-1:0] prog_addr;
  logic [7:0]    prog_data;
  logic          prog_done = 1'b0;
  logic          prot_we = 1'b0;
  logic [SW-1:0] prot_sector = '0;
  logic          prot_value = 1'b0;
  logic [1:0]    mode;

  always #5 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .prog_start(prog_start),
    .prog_addr(prog_addr), .prog_data(prog_data), .prog_done(prog_done),
    .prot_we(prot_we), .prot_sector(prot_sector), .prot_value(prot_value), .mode(mode)
  );

  // external array stub
  logic [7:0] mem [0:(1<<AW)-1];
  initial for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i) ^ 8'h5A;
  assign arr_rdata = mem[arr_raddr];

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_st = 0;            // 0 read,1 unl1,2 unl2,3 setup,4 auto,5 busy
  int m_tog = 0;
  int m_paddr = 0, m_pdata = 0;
  int m_prot [8];
  int exp_rv = 0, exp_rd = 0, exp_start = 0;

  function automatic int mode_of(int s);
    case (s)
      0: return 0;
      4: return 1;
      5: return 3;
      default: return 2;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_tog = 0; m_paddr = 0; m_pdata = 0;
      exp_rv = 0; exp_rd = 0; exp_start = 0;
      foreach (m_prot[i]) m_prot[i] = 0;
    end else begin
      int n, ca, lo;
      n = m_st;
      exp_start = 0;
      exp_rv = rd_req;
      if (rd_req) begin
        lo = int'(rd_addr) & 'hFF;
        if (m_st == 5) exp_rd = ((m_pdata & 'h80) ^ 'h80) | (m_tog << 6);
        else if (m_st == 4) exp_rd = (lo == 0) ? 'h01 : (lo == 1) ? 'h38 :
                                     (lo == 2) ? m_prot[int'(rd_addr) >> 9] : 0;
        else exp_rd = int'(mem[rd_addr]);
      end
      if (m_st != 5) m_tog = 0;
      else if (rd_req) m_tog ^= 1;
      ca = int'(wr_addr) & 'h7FF;
      if (m_st == 5) begin
        if (prog_done) n = 0;
      end else if (wr_valid) begin
        case (m_st)
          0: if (wr_data == 8'hAA && ca == 'h555) n = 1;
          1: n = (wr_data == 8'h55 && ca == 'h2AA) ? 2 : 0;
          2: n = (ca == 'h555 && wr_data == 8'hA0) ? 3 :
                 (ca == 'h555 && wr_data == 8'h90) ? 4 : 0;
          3: begin
            if (wr_data == 8'hF0 || m_prot[int'(wr_addr) >> 9] != 0) n = 0;
            else begin
              n = 5; exp_start = 1; m_paddr = int'(wr_addr); m_pdata = int'(wr_data);
            end
          end
          4: if (wr_data == 8'hF0) n = 0;
          default: ;
        endcase
      end
      if (prot_we) m_prot[prot_sector] = int'(prot_value);
      m_st = n;
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // compare every clock, away from the edge
  always @(posedge clk) begin
    #2;
    chk(int'(mode), mode_of(m_st), "mode");
    chk(int'(rd_valid), exp_rv, "rd_valid");
    chk(int'(prog_start), exp_start, "prog_start");
    if (exp_rv != 0) chk(int'(rd_data), exp_rd, "rd_data");
    if (exp_start != 0) begin
      chk(int'(prog_addr), m_paddr, "prog_addr");
      chk(int'(prog_data), m_pdata, "prog_data");
    end
  end

  task automatic cyc(input bit wv, input int wa, input int wd,
                     input bit rq, input int ra, input bit dn);
    @(negedge clk);
    wr_valid = wv; wr_addr = AW'(wa); wr_data = 8'(wd);
    rd_req = rq; rd_addr = AW'(ra); prog_done = dn; prot_we = 1'b0;
    if (dn && m_st == 5) mem[m_paddr] = 8'(m_pdata);
  endtask

  task automatic wr(input int a, input int d); cyc(1, a, d, 0, 0, 0); endtask
  task automatic rd(input int a); cyc(0, 0, 0, 1, a, 0); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0, 0); endtask
  task automatic done(); cyc(0, 0, 0, 0, 0, 1); endtask
  task automatic unlock(); wr('h555, 'hAA); wr('h2AA, 'h55); endtask
  task automatic protect(input int s, input bit v);
    @(negedge clk);
    wr_valid = 0; rd_req = 0; prog_done = 0;
    prot_we = 1; prot_sector = SW'(s); prot_value = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(); idle();

    cur_req = "R2";
    rd('h010); rd('h7FF); rd('hC33); idle();

    cur_req = "R3";
    unlock(); wr('h555, 'hA0); wr('h123, 'h3C);
    cur_req = "R7";
    rd('h000); rd('h123); rd('h555); idle();
    cur_req = "R6";
    done(); idle();
    cur_req = "R2";
    rd('h123); idle();

    cur_req = "R4";
    wr('h555, 'hAA); wr('h2AB, 'h55); wr('h2AA, 'h55); wr('h555, 'hA0); wr('h100, 'h11); idle();
    wr('h555, 'hAA); wr('h2AA, 'h56); idle();
    unlock(); wr('h555, 'hA1); wr('h100, 'h22); idle();
    unlock(); wr('h554, 'hA0); wr('h100, 'h33); idle();

    cur_req = "R5";
    wr('h555, 'hAA); wr('h7E1, 'hF0); idle();
    unlock(); wr('h000, 'hF0); idle();
    unlock(); wr('h555, 'hA0); rd('h044); wr('h044, 'hF0); rd('h044); idle();

    cur_req = "R6";
    unlock(); wr('h555, 'hA0); wr('h250, 'hC1);
    wr('h000, 'hF0); unlock(); wr('h555, 'h90); rd('h250);
    cur_req = "R7";
    rd('h250); rd('h250); rd('h001);
    cur_req = "R11";
    cyc(1, 'h555, 'hAA, 1, 'h250, 1);
    wr('h2AA, 'h55); rd('h001); idle();

    cur_req = "R8";
    unlock(); wr('h555, 'h90);
    cur_req = "R9";
    rd('h000); rd('h701); rd('h302); rd('h003); rd('hFFF);
    cur_req = "R8";
    wr('h555, 'hAA); wr('h123, 'h00); rd('h501); wr('h3CD, 'hF0); rd('h001); idle();

    cur_req = "R10";
    protect(5, 1); idle();
    unlock(); wr('h555, 'hA0); wr('hA10, 'h99); rd('hA10); idle();
    unlock(); wr('h555, 'h90);
    cur_req = "R9";
    rd('hA02); rd('h402); wr('h000, 'hF0);
    cur_req = "R10";
    protect(5, 0); idle();
    unlock(); wr('h555, 'hA0); wr('hA10, 'h99); idle(); done(); rd('hA10); idle();

    cur_req = "R11";
    done(); idle();
    cyc(1, 'h555, 'hAA, 1, 'h555, 0);
    cyc(1, 'h2AA, 'h55, 1, 'h2AA, 0);
    cyc(1, 'h555, 'h90, 1, 'h000, 0);
    cyc(0, 0, 0, 1, 'h000, 1);
    wr('h0, 'hF0); idle(); idle();

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule